// File: doc/BRIEF.md
# Segmented Profile Sweep Sequencer

This block steps through the address space of a 1024-word, 32-bit waveform RAM whose output drives an NCO. The RAM holds four segments, and each has its own programmable first and last address. A 2-bit profile input picks the active segment. A control register picks one of five stepping behaviours: a direct jump, a one-shot upward ramp, a ramp whose direction follows an input level, an endless up-and-down sweep, and an endless wrap-around sweep. A programmable ramp-rate counter sets the pace of each stepping behaviour.

Each cycle the block presents the current RAM address, the word read from that address and a valid flag. It also routes the word to one of two places. With the destination bit clear, the word becomes the frequency tuning word and the phase offset comes from its own register. With the bit set, the roles are exchanged. In ramp mode the block can also emit a one-cycle pulse that clears the NCO's accumulator when a sweep ends. Software loads the RAM and the configuration registers through two simple write ports.

Top module: `seg_sweep_seq`

## Requirements
- R1: While reset is held, `ram_addr` is 0, `acc_clr` is 0 and `data_valid` is 0. All configuration registers reset to 0, which selects mode 0.
- R2: A write with `reg_we` high goes to the register chosen by `reg_sel`:
  - Values 0 to 3 write segment n. Bits [9:0] hold its start address and bits [25:16] hold its end address.
  - Value 4 writes the ramp rate in bits [15:0].
  - Value 5 writes control. Bits [2:0] hold the mode, bit 3 is no-dwell and bit 4 is the destination.
  - Value 6 writes the fixed frequency word. Value 7 writes the fixed phase word.
- R3: A restart loads the ramp counter with the rate R, where a rate of 0 counts as 1. Stepping modes advance at most once every R cycles, and the first step comes R cycles after the restart.
- R4: Mode 0 (direct). A change on `prof_sel` loads the start address of segment `prof_sel` at the next clock edge. The address then holds, and ramp ticks do not move it.
- R5: Mode 1 (ramp up). A restart happens on a profile change or on an `upd` pulse, and it loads the segment start. The address then rises by one per tick up to the end address, where it holds.
- R6: In mode 1 with no-dwell set, the first tick after the address reaches the end raises `acc_clr` for exactly one cycle, once per sweep. With no-dwell clear, `acc_clr` stays low.
- R7: Mode 2 (level bidirectional). The block always uses segment 0, and `upd` restarts the sweep at its start address. On each tick, `prof_sel[0]` = 1 steps the address up and 0 steps it down. The address saturates at the segment bounds. A `prof_sel` change does not restart the sweep.
- R8: Mode 3 (continuous bidirectional). After a restart, the address rises one per tick to the end and then falls one per tick to the start, over and over. With L = end - start, the period is 2L ticks.
- R9: Mode 4 (recirculate). After a restart, the address rises one per tick. The tick after it reaches the end reloads the start address.
- R10: `ram_word` is the RAM content at the address held one cycle earlier. `data_valid` is 1 exactly when that address equals the current `ram_addr` and no RAM write hit it in that cycle.
- R11: With the destination bit at 0, `ftw_out` = `ram_word` and `phase_out` = the fixed phase word. With the bit at 1, `phase_out` = `ram_word` and `ftw_out` = the fixed frequency word. `dest_phase` shows the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_we | input | 1 | RAM write enable |
| ram_waddr | input | 10 | RAM write address |
| ram_wdata | input | 32 | RAM write data |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| prof_sel | input | 2 | Profile / segment select; bit 0 is the direction in mode 2 |
| upd | input | 1 | Update strobe, restarts the sweep |
| ram_addr | output | 10 | Current RAM address |
| ram_word | output | 32 | RAM word read one cycle earlier |
| data_valid | output | 1 | ram_word belongs to ram_addr |
| dest_phase | output | 1 | 1 when the RAM word drives the phase |
| ftw_out | output | 32 | Frequency tuning word to the NCO |
| phase_out | output | 32 | Phase offset word to the NCO |
| acc_clr | output | 1 | One-cycle accumulator clear request |

## Verification
The assertions check these properties on every cycle:
- the ramp counter never reaches zero;
- the address moves only on a restart or a tick;
- a restart always lands on the segment start;
- recirculation wraps from the end back to the start;
- the clear pulse lasts a single cycle;
- a valid word always matches the RAM content at the current address.

Only the bench scenarios can show the address sequences over time. These cover the saturation and period of each mode at several ramp rates and across segments of different lengths, the timing of the no-dwell pulse, the fact that a profile change does not restart mode 2, and the routing of the output to frequency or phase.

// File: rtl/seg_sweep_seq.sv
module seg_sweep_seq #(
  parameter int AW  = 10,
  parameter int DW  = 32,
  parameter int RW  = 16,
  parameter int PSW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ram_we,
  input  logic [AW-1:0] ram_waddr,
  input  logic [DW-1:0] ram_wdata,
  input  logic          reg_we,
  input  logic [PSW:0]  reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic [PSW-1:0] prof_sel,
  input  logic          upd,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_word,
  output logic          data_valid,
  output logic          dest_phase,
  output logic [DW-1:0] ftw_out,
  output logic [DW-1:0] phase_out,
  output logic          acc_clr
);
  localparam int NSEG  = 1 << PSW;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] M_DIRECT = 3'd0, M_RAMP = 3'd1, M_BIDIR = 3'd2,
                         M_CBIDIR = 3'd3, M_RECIRC = 3'd4;
  localparam logic [RW-1:0] ONE = {{(RW-1){1'b0}}, 1'b1};

  logic [AW-1:0] seg_lo [NSEG];
  logic [AW-1:0] seg_hi [NSEG];
  logic [RW-1:0] rate_q, cnt_q;
  logic [2:0]    mode_q;
  logic          nodwell_q, dest_q;
  logic [DW-1:0] ftw_q, phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        seg_lo[i] <= '0;
        seg_hi[i] <= '0;
      end
      rate_q <= '0; mode_q <= M_DIRECT; nodwell_q <= 1'b0; dest_q <= 1'b0;
      ftw_q <= '0; phase_q <= '0;
    end else if (reg_we) begin
      if (!reg_sel[PSW]) begin
        seg_lo[reg_sel[PSW-1:0]] <= reg_wdata[AW-1:0];
        seg_hi[reg_sel[PSW-1:0]] <= reg_wdata[16+AW-1:16];
      end else begin
        case (reg_sel[1:0])
          2'd0: rate_q <= reg_wdata[RW-1:0];
          2'd1: begin
            mode_q    <= reg_wdata[2:0];
            nodwell_q <= reg_wdata[3];
            dest_q    <= reg_wdata[4];
          end
          2'd2: ftw_q   <= reg_wdata;
          default: phase_q <= reg_wdata;
        endcase
      end
    end
  end

  logic [PSW-1:0] prof_q, seg;
  logic [AW-1:0]  lo, hi, addr_q, addr_n;
  logic [RW-1:0]  rate_eff;
  logic           dir_q, dir_n, done_q, done_n, clr_q, clr_n;
  logic           restart, tick;

  assign rate_eff = (rate_q == '0) ? ONE : rate_q;
  assign seg      = (mode_q == M_BIDIR) ? '0 : prof_sel;
  assign lo       = seg_lo[seg];
  assign hi       = seg_hi[seg];
  assign restart  = upd | ((prof_sel != prof_q) & (mode_q != M_BIDIR));
  assign tick     = (cnt_q == ONE);

  always_comb begin
    addr_n = addr_q;
    dir_n  = dir_q;
    done_n = done_q;
    clr_n  = 1'b0;
    if (restart) begin
      addr_n = lo;
      dir_n  = 1'b1;
      done_n = 1'b0;
    end else if (tick) begin
      case (mode_q)
        M_RAMP:
          if (addr_q < hi) addr_n = addr_q + 1'b1;
          else if (nodwell_q && !done_q) begin
            clr_n  = 1'b1;
            done_n = 1'b1;
          end
        M_BIDIR:
          if (prof_sel[0]) begin
            if (addr_q < hi) addr_n = addr_q + 1'b1;
          end else if (addr_q > lo) addr_n = addr_q - 1'b1;
        M_CBIDIR:
          if (dir_q) begin
            if (addr_q < hi) addr_n = addr_q + 1'b1;
            else begin
              dir_n = 1'b0;
              if (addr_q > lo) addr_n = addr_q - 1'b1;
            end
          end else begin
            if (addr_q > lo) addr_n = addr_q - 1'b1;
            else begin
              dir_n = 1'b1;
              if (addr_q < hi) addr_n = addr_q + 1'b1;
            end
          end
        M_RECIRC:
          addr_n = (addr_q >= hi) ? lo : addr_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; cnt_q <= ONE; prof_q <= '0;
      dir_q <= 1'b1; done_q <= 1'b0; clr_q <= 1'b0;
    end else begin
      addr_q <= addr_n;
      dir_q  <= dir_n;
      done_q <= done_n;
      clr_q  <= clr_n;
      prof_q <= prof_sel;
      cnt_q  <= (restart || tick) ? rate_eff : cnt_q - 1'b1;
    end
  end

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [AW-1:0] tag_q;
  logic          fresh_q;

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_waddr] <= ram_wdata;
    rd_q  <= mem[addr_q];
    tag_q <= addr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fresh_q <= 1'b0;
    else        fresh_q <= !(ram_we && ram_waddr == addr_q);
  end

  assign ram_addr   = addr_q;
  assign ram_word   = rd_q;
  assign data_valid = fresh_q && (tag_q == addr_q);
  assign dest_phase = dest_q;
  assign ftw_out    = dest_q ? ftw_q : rd_q;
  assign phase_out  = dest_q ? rd_q : phase_q;
  assign acc_clr    = clr_q;

  a_r3_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0) else $error("ramp counter reached zero");
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(addr_q)) else $error("address moved without tick");
  a_r4_restart_loads_start: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> addr_q == $past(lo)) else $error("restart missed segment start");
  a_r9_recirc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RECIRC && tick && !restart && !reg_we && addr_q >= hi)
      |=> addr_q == $past(lo)) else $error("recirculation did not wrap");
  a_r6_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> !acc_clr) else $error("clear pulse longer than one cycle");
  a_r10_valid_word: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> ram_word == mem[ram_addr]) else $error("valid word mismatch");
endmodule

// File: tb/seg_sweep_seq_tb.sv
module seg_sweep_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ram_we = 1'b0;
  logic [9:0]  ram_waddr = '0;
  logic [31:0] ram_wdata = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  prof_sel = '0;
  logic        upd = 1'b0;
  logic [9:0]  ram_addr;
  logic [31:0] ram_word, ftw_out, phase_out;
  logic        data_valid, dest_phase, acc_clr;

  int errors = 0;
  int checks = 0;
  int S [4] = '{10, 100, 500, 1018};
  int E [4] = '{15, 103, 500, 1023};

  seg_sweep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .prof_sel(prof_sel), .upd(upd),
    .ram_addr(ram_addr), .ram_word(ram_word), .data_valid(data_valid),
    .dest_phase(dest_phase), .ftw_out(ftw_out), .phase_out(phase_out),
    .acc_clr(acc_clr));

  always #5 clk = ~clk;

  function automatic logic [31:0] fword(input int a);
    return 32'h5A00_0000 ^ (a * 32'h0001_0003);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input int sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel[2:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic int exp_addr(input int mode, input int s, input int e, input int st);
    int l = e - s;
    int p;
    if (mode == 1) return (s + st < e) ? s + st : e;
    if (mode == 4) return s + (st % (l + 1));
    if (l == 0) return s;
    p = st % (2 * l);
    return (p <= l) ? s + p : s + 2 * l - p;
  endfunction

  task automatic sweep(input int mode, input int sg, input int r, input int nd);
    int l = E[sg] - S[sg];
    int n = (2 * l + 3) * r;
    int ex;
    string tg;
    tg = (mode == 1) ? "R5" : (mode == 3) ? "R8" : "R9";
    wr_reg(4, r);
    wr_reg(5, (nd << 3) | mode);
    prof_sel = sg[1:0]; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    for (int k = 0; k <= n; k++) begin
      ex = exp_addr(mode, S[sg], E[sg], k / r);
      chk(tg, ram_addr, ex);
      if (mode == 1) chk("R6", acc_clr, (nd != 0 && k == (l + 1) * r) ? 1 : 0);
      if (r > 1 && (k % r) != 0) begin
        chk("R10 valid", data_valid, 1);
        chk("R10 word", ram_word, fword(ex));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 addr", ram_addr, 0);
    chk("R1 clr", acc_clr, 0);
    chk("R1 valid", data_valid, 0);
    chk("R1 dest", dest_phase, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 1024; a++) begin
      ram_we = 1'b1; ram_waddr = a[9:0]; ram_wdata = fword(a);
      @(negedge clk);
    end
    ram_we = 1'b0;
    // R2 segment bounds
    for (int i = 0; i < 4; i++) wr_reg(i, (E[i] << 16) | S[i]);
    wr_reg(6, 32'h1234_5678);
    wr_reg(7, 32'h9ABC_DEF0);

    // R4 direct switch
    wr_reg(5, 0);
    for (int i = 1; i <= 4; i++) begin
      prof_sel = i[1:0];
      @(negedge clk);
      chk("R4 load", ram_addr, S[i % 4]);
      repeat (3) @(negedge clk);
      chk("R4 hold", ram_addr, S[i % 4]);
      chk("R10 valid", data_valid, 1);
      chk("R10 word", ram_word, fword(S[i % 4]));
    end

    // R11 destination routing, segment 1
    prof_sel = 2'd1;
    repeat (3) @(negedge clk);
    chk("R11 ftw", ftw_out, fword(S[1]));
    chk("R11 phase", phase_out, 32'h9ABC_DEF0);
    wr_reg(5, 32'h10);
    chk("R11 dest", dest_phase, 1);
    chk("R11 ftw", ftw_out, 32'h1234_5678);
    chk("R11 phase", phase_out, fword(S[1]));
    wr_reg(5, 0);

    // R3 R5 R8 R9 sweeps over segments and rates
    for (int m = 0; m < 3; m++)
      for (int sg = 0; sg < 4; sg++)
        for (int r = 1; r <= 3; r++)
          sweep((m == 0) ? 1 : (m == 1) ? 3 : 4, sg, r, 0);
    // R6 no-dwell
    for (int sg = 0; sg < 4; sg++) sweep(1, sg, 2, 1);
    sweep(1, 1, 3, 1);

    // R3 rate 0 behaves as 1
    wr_reg(4, 0);
    wr_reg(5, 4);
    prof_sel = 2'd0; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R3 rate0", ram_addr, S[0] + (k % 6));
      @(negedge clk);
    end

    // R7 level bidirectional on segment 0
    wr_reg(4, 2);
    wr_reg(5, 2);
    prof_sel = 2'd3; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    for (int k = 0; k < 16; k++) begin
      chk("R7 up", ram_addr, (S[0] + k / 2 < E[0]) ? S[0] + k / 2 : E[0]);
      @(negedge clk);
    end
    prof_sel = 2'd1;
    @(negedge clk);
    chk("R7 no restart", ram_addr, E[0]);
    prof_sel = 2'd2;
    prev = ram_addr;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R7 down step", ((prev - ram_addr) <= 1 && ram_addr <= prev) ? 1 : 0, 1);
      prev = ram_addr;
    end
    chk("R7 low bound", ram_addr, S[0]);
    repeat (5) @(negedge clk);
    chk("R7 saturate", ram_addr, S[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule